// File: doc/BRIEF.md
# Serial Flash Controller Register Front-End

This block is the register file and interrupt logic that sits between a 32-bit word-addressed register bus and the transfer engine of a serial-flash controller. It holds the settings that the engine reads: a global control word, the command word, the flash address, the FIFO threshold and the DMA buffer address. Software reads back the FIFO levels and flags, the engine busy state, and both the raw and the masked interrupt status.

A write to the command register while the engine is idle starts a transfer by sending a one-cycle start strobe to the sequencer. A write of bit 0 to the DMA trigger register sends a one-cycle DMA strobe. Completion and error events from the sequencer and the DMA datapath arrive as single-cycle pulses and are latched as raw interrupt bits. Software clears them by writing ones to a clear register. The data port forwards pushes to the transmit FIFO and pops from the receive FIFO, which live outside the block. A soft reset held for a fixed number of cycles wipes the registers and flushes both FIFOs.

Top module: `sfc_regfront`

## Requirements
- R1: After the reset input is released, control, mask, threshold, command, address, DMA address and raw status all read 0. The FIFO status reads 0x6 when both levels are 0. seq_start, dma_start and irq are low.
- R2: When the engine is not busy, a write to control (0x00) keeps only bits 1 and 13:8. All other bits read 0.
- R3: A control write while the engine is busy leaves the control register unchanged.
- R4: A command write (0x100) while seq_busy is low stores the word and raises seq_start for exactly the next cycle. While seq_busy is high, the write stores nothing and gives no strobe.
- R5: Writing 1 in bit 0 of the DMA trigger (0x80) raises dma_start for one cycle. The trigger reads 0. The DMA address (0x84) reads back the value written.
- R6: Writing 1 in bit 0 of 0x10 starts a soft reset. That bit reads 1 and fifo_flush is high for RST_CYCLES (4) cycles, then both return to 0. The reset zeroes control, mask, command, address and raw status. Bus writes made during the reset are ignored.
- R7: Raw status (0x28) latches events at these bit positions: 0 receive FIFO becoming full, 1 receive underflow, 2 transmit overflow, 3 transmit FIFO becoming empty, 4 transfer done, 5 bus error, 6 serial error, 7 DMA done.
- R8: Writing to the clear register (0x08) clears each raw bit whose write-data bit is 1 and leaves every other raw bit unchanged.
- R9: Masked status (0x1C) equals raw AND NOT mask (0x04, where 1 means suppressed). irq is the OR of the masked bits.
- R10: FIFO status (0x20) has transmit full at bit 0, transmit empty at bit 1, receive empty at bit 2 and receive full at bit 3. It also holds the transmit level in bits 12:8 and the receive level in bits 20:16. A FIFO counts as full when its level equals FIFO_DEPTH.
- R11: A write to the data port (0x108) pulses tx_push with the write data, unless the transmit FIFO is full. In that case there is no push and raw bit 2 is set.
- R12: A read of the data port returns rx_rdata and pulses rx_pop, unless the receive FIFO is empty. In that case there is no pop and raw bit 1 is set.
- R13: Engine status (0x24) bit 0 reads 1 while seq_busy is high or a soft reset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| seq_busy | input | 1 | Transfer engine busy |
| seq_start | output | 1 | One-cycle transfer launch |
| seq_ctrl | output | 32 | Control register value |
| seq_cmd | output | 32 | Command register value |
| seq_addr | output | 32 | Flash address register |
| seq_thresh | output | 32 | FIFO threshold register |
| dma_start | output | 1 | One-cycle DMA launch |
| dma_addr | output | 32 | DMA buffer address |
| ev_xfer_done | input | 1 | Transfer finished pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| ev_ser_err | input | 1 | Serial error pulse |
| ev_dma_done | input | 1 | DMA finished pulse |
| tx_level | input | LVL_W | Transmit FIFO level |
| tx_push | output | 1 | Push strobe to transmit FIFO |
| tx_wdata | output | 32 | Data to transmit FIFO |
| rx_level | input | LVL_W | Receive FIFO level |
| rx_pop | output | 1 | Pop strobe to receive FIFO |
| rx_rdata | input | 32 | Head word of receive FIFO |
| fifo_flush | output | 1 | Empty both FIFOs |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH = 16 and RST_CYCLES = 4. It drives both FIFO levels directly, so it can set either level to exactly 16 or to 0 on any cycle. This puts both full and empty, the full and empty edges, and the overflow and underflow cases within reach without a real FIFO. With a four-cycle reset, the bench can read the self-clearing reset bit on every cycle of its life and confirm the first cycle after it ends.

// File: rtl/sfc_rf_pkg.sv
package sfc_rf_pkg;
  localparam int OFF_CTRL   = 'h000;
  localparam int OFF_IMASK  = 'h004;
  localparam int OFF_ICLR   = 'h008;
  localparam int OFF_THR    = 'h00C;
  localparam int OFF_RCVR   = 'h010;
  localparam int OFF_MSTAT  = 'h01C;
  localparam int OFF_FSTAT  = 'h020;
  localparam int OFF_ESTAT  = 'h024;
  localparam int OFF_RAW    = 'h028;
  localparam int OFF_DMATRG = 'h080;
  localparam int OFF_DMAADR = 'h084;
  localparam int OFF_CMD    = 'h100;
  localparam int OFF_ADDR   = 'h104;
  localparam int OFF_DATA   = 'h108;

  localparam int IRQ_N = 8;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_3F02;

  typedef enum logic [2:0] {
    IB_RXFULL = 3'd0, IB_RXUNF = 3'd1, IB_TXOVF = 3'd2, IB_TXEMP = 3'd3,
    IB_DONE = 3'd4, IB_BUSERR = 3'd5, IB_SERERR = 3'd6, IB_DMADONE = 3'd7
  } irq_bit_e;

  function automatic logic [31:0] fstat_pack(input logic [4:0] txl, input logic [4:0] rxl,
                                             input logic txf, input logic txe,
                                             input logic rxe, input logic rxf);
    logic [31:0] v;
    v = '0;
    v[0] = txf; v[1] = txe; v[2] = rxe; v[3] = rxf;
    v[12:8] = txl;
    v[20:16] = rxl;
    return v;
  endfunction

  function automatic logic [IRQ_N-1:0] irq_masked(input logic [IRQ_N-1:0] raw,
                                                  input logic [IRQ_N-1:0] msk);
    return raw & ~msk;
  endfunction
endpackage

// File: rtl/sfc_rf_rst.sv
module sfc_rf_rst #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic active
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (kick && cnt_q == '0) cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/sfc_rf_fifo_port.sv
module sfc_rf_fifo_port #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  output logic             tx_push,
  output logic             rx_pop,
  output logic             ovf_evt,
  output logic             unf_evt,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rxf_rise,
  output logic             txe_rise
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
  logic txe_prev_q, rxf_prev_q;

  assign tx_full  = (tx_level >= FULL_LVL);
  assign tx_empty = (tx_level == '0);
  assign rx_full  = (rx_level >= FULL_LVL);
  assign rx_empty = (rx_level == '0);

  assign tx_push = wr_req && !tx_full;
  assign ovf_evt = wr_req && tx_full;
  assign rx_pop  = rd_req && !rx_empty;
  assign unf_evt = rd_req && rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_prev_q <= 1'b1;
      rxf_prev_q <= 1'b0;
    end else begin
      txe_prev_q <= tx_empty;
      rxf_prev_q <= rx_full;
    end
  end

  assign rxf_rise = rx_full && !rxf_prev_q;
  assign txe_rise = tx_empty && !txe_prev_q;
endmodule

// File: rtl/sfc_rf_irq.sv
module sfc_rf_irq
  import sfc_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic [IRQ_N-1:0] set_vec,
  input  logic [IRQ_N-1:0] clr_vec,
  input  logic [IRQ_N-1:0] mask,
  output logic [IRQ_N-1:0] raw,
  output logic [IRQ_N-1:0] masked,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else if (wipe) raw <= '0;
    else raw <= (raw & ~clr_vec) | set_vec;
  end

  assign masked = irq_masked(raw, mask);
  assign irq = |masked;
endmodule

// File: rtl/sfc_regfront.sv
module sfc_regfront
  import sfc_rf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int FIFO_DEPTH = 16,
  parameter int RST_CYCLES = 4,
  parameter int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             seq_busy,
  output logic             seq_start,
  output logic [31:0]      seq_ctrl,
  output logic [31:0]      seq_cmd,
  output logic [31:0]      seq_addr,
  output logic [31:0]      seq_thresh,
  output logic             dma_start,
  output logic [31:0]      dma_addr,
  input  logic             ev_xfer_done,
  input  logic             ev_bus_err,
  input  logic             ev_ser_err,
  input  logic             ev_dma_done,
  input  logic [LVL_W-1:0] tx_level,
  output logic             tx_push,
  output logic [31:0]      tx_wdata,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rx_pop,
  input  logic [31:0]      rx_rdata,
  output logic             fifo_flush,
  output logic             irq
);
  localparam int WA_W = ADDR_W - 2;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a[ADDR_W-1:2] == WA_W'(off >> 2);
  endfunction

  // named internal events
  logic rst_active, busy, wr_ok, rd_ok, soft_clr;
  logic ctrl_wr, cmd_wr, dma_trg;
  logic ovf_evt, unf_evt, tx_full, tx_empty, rx_full, rx_empty, rxf_rise, txe_rise;
  logic [IRQ_N-1:0] imask_q, raw, masked, set_vec, clr_vec;
  logic [31:0] ctrl_q, cmd_q, addr_q, thr_q, dmaadr_q;
  logic start_q, dma_q;

  assign wr_ok    = bus_sel && bus_wr && !rst_active;
  assign rd_ok    = bus_sel && !bus_wr && !rst_active;
  assign busy     = seq_busy || rst_active;
  assign soft_clr = wr_ok && hit(bus_addr, OFF_RCVR) && bus_wdata[0];
  assign ctrl_wr  = wr_ok && hit(bus_addr, OFF_CTRL) && !busy;
  assign cmd_wr   = wr_ok && hit(bus_addr, OFF_CMD) && !seq_busy;
  assign dma_trg  = wr_ok && hit(bus_addr, OFF_DMATRG) && bus_wdata[0];

  sfc_rf_rst #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .kick(soft_clr), .active(rst_active)
  );

  sfc_rf_fifo_port #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fport (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_ok && hit(bus_addr, OFF_DATA)),
    .rd_req(rd_ok && hit(bus_addr, OFF_DATA)),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .rx_pop(rx_pop),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .rxf_rise(rxf_rise), .txe_rise(txe_rise)
  );

  always_comb begin
    set_vec = '0;
    set_vec[IB_RXFULL]  = rxf_rise;
    set_vec[IB_RXUNF]   = unf_evt;
    set_vec[IB_TXOVF]   = ovf_evt;
    set_vec[IB_TXEMP]   = txe_rise;
    set_vec[IB_DONE]    = ev_xfer_done;
    set_vec[IB_BUSERR]  = ev_bus_err;
    set_vec[IB_SERERR]  = ev_ser_err;
    set_vec[IB_DMADONE] = ev_dma_done;
    clr_vec = (wr_ok && hit(bus_addr, OFF_ICLR)) ? bus_wdata[IRQ_N-1:0] : '0;
  end

  sfc_rf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wipe(soft_clr || rst_active),
    .set_vec(set_vec), .clr_vec(clr_vec), .mask(imask_q),
    .raw(raw), .masked(masked), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; cmd_q <= '0; addr_q <= '0; thr_q <= '0;
      dmaadr_q <= '0; imask_q <= '0; start_q <= 1'b0; dma_q <= 1'b0;
    end else if (soft_clr) begin
      ctrl_q <= '0; cmd_q <= '0; addr_q <= '0; thr_q <= '0;
      dmaadr_q <= '0; imask_q <= '0; start_q <= 1'b0; dma_q <= 1'b0;
    end else begin
      start_q <= cmd_wr;
      dma_q   <= dma_trg;
      if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_WMASK;
      if (cmd_wr) cmd_q <= bus_wdata;
      if (wr_ok && hit(bus_addr, OFF_ADDR)) addr_q <= bus_wdata;
      if (wr_ok && hit(bus_addr, OFF_THR)) thr_q <= bus_wdata;
      if (wr_ok && hit(bus_addr, OFF_DMAADR)) dmaadr_q <= bus_wdata;
      if (wr_ok && hit(bus_addr, OFF_IMASK)) imask_q <= bus_wdata[IRQ_N-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFF_CTRL))        bus_rdata = ctrl_q;
    else if (hit(bus_addr, OFF_IMASK))  bus_rdata = 32'(imask_q);
    else if (hit(bus_addr, OFF_THR))    bus_rdata = thr_q;
    else if (hit(bus_addr, OFF_RCVR))   bus_rdata = 32'(rst_active);
    else if (hit(bus_addr, OFF_MSTAT))  bus_rdata = 32'(masked);
    else if (hit(bus_addr, OFF_FSTAT))
      bus_rdata = fstat_pack(5'(tx_level), 5'(rx_level), tx_full, tx_empty, rx_empty, rx_full);
    else if (hit(bus_addr, OFF_ESTAT))  bus_rdata = 32'(busy);
    else if (hit(bus_addr, OFF_RAW))    bus_rdata = 32'(raw);
    else if (hit(bus_addr, OFF_DMAADR)) bus_rdata = dmaadr_q;
    else if (hit(bus_addr, OFF_CMD))    bus_rdata = cmd_q;
    else if (hit(bus_addr, OFF_ADDR))   bus_rdata = addr_q;
    else if (hit(bus_addr, OFF_DATA))   bus_rdata = rx_rdata;
  end

  assign seq_start  = start_q;
  assign dma_start  = dma_q;
  assign seq_ctrl   = ctrl_q;
  assign seq_cmd    = cmd_q;
  assign seq_addr   = addr_q;
  assign seq_thresh = thr_q;
  assign dma_addr   = dmaadr_q;
  assign tx_wdata   = bus_wdata;
  assign fifo_flush = rst_active;
endmodule

// File: rtl/sfc_rf_chk.sv
module sfc_rf_chk
  import sfc_rf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int RST_CYCLES = 4,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             seq_busy,
  input logic             busy,
  input logic             rst_active,
  input logic             seq_start,
  input logic             dma_start,
  input logic [31:0]      ctrl_q,
  input logic [IRQ_N-1:0] imask_q,
  input logic [IRQ_N-1:0] raw,
  input logic             irq,
  input logic             rx_pop,
  input logic             tx_push,
  input logic [LVL_W-1:0] rx_level
);
  logic a_ctrl, a_cmd, a_dma, a_data;
  assign a_ctrl = bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_CTRL >> 2);
  assign a_cmd  = bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_CMD >> 2);
  assign a_dma  = bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_DMATRG >> 2);
  assign a_data = bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_DATA >> 2);

  logic [7:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (rst_active) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && a_ctrl && busy) |=> $stable(ctrl_q));
  // R4
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_start) |-> $past(bus_sel && bus_wr && a_cmd && !seq_busy));
  // R5
  dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> $past(bus_sel && bus_wr && a_dma && bus_wdata[0]));
  // R6
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(RST_CYCLES));
  // R6
  rst_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_active) |-> (raw == '0));
  // R9
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&imask_q) |-> !irq);
  // R12
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_pop && rx_level == '0));
  // R12
  unf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && a_data && rx_level == '0 && !rst_active) |=> raw[1]);
  // R11
  push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (bus_sel && bus_wr && a_data));
endmodule

bind sfc_regfront sfc_rf_chk #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .seq_busy(seq_busy), .busy(busy), .rst_active(rst_active),
  .seq_start(seq_start), .dma_start(dma_start), .ctrl_q(ctrl_q), .imask_q(imask_q),
  .raw(raw), .irq(irq), .rx_pop(rx_pop), .tx_push(tx_push), .rx_level(rx_level)
);

// File: tb/sfc_regfront_tb.sv
`timescale 1ns/1ps
module sfc_regfront_tb;
  localparam int AW = 9;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic seq_busy = 1'b0, seq_start;
  logic [31:0] seq_ctrl, seq_cmd, seq_addr, seq_thresh, dma_addr, tx_wdata;
  logic dma_start, tx_push, rx_pop, fifo_flush, irq;
  logic ev_xfer_done = 1'b0, ev_bus_err = 1'b0, ev_ser_err = 1'b0, ev_dma_done = 1'b0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic [31:0] rx_rdata = '0;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sfc_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_busy(seq_busy), .seq_start(seq_start),
    .seq_ctrl(seq_ctrl), .seq_cmd(seq_cmd), .seq_addr(seq_addr), .seq_thresh(seq_thresh),
    .dma_start(dma_start), .dma_addr(dma_addr), .ev_xfer_done(ev_xfer_done),
    .ev_bus_err(ev_bus_err), .ev_ser_err(ev_ser_err), .ev_dma_done(ev_dma_done),
    .tx_level(tx_level), .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_level(rx_level),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .fifo_flush(fifo_flush), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // called just after a falling edge; returns at the next falling edge
  task automatic wr(input int a, input logic [31:0] d, output logic pushed);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    #1 pushed = tx_push;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr0(input int a, input logic [31:0] d);
    logic p;
    wr(a, d, p);
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic popped);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata; popped = rx_pop;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] rd_now(input int a);
    return 32'h0;
  endfunction

  task automatic rdv(input int a, output logic [31:0] d);
    logic p;
    rd(a, d, p);
  endtask

  function automatic logic [31:0] exp_fstat(input int t, input int r);
    logic [31:0] v;
    v = (32'(t) << 8) | (32'(r) << 16);
    if (t == 16) v |= 32'h1;
    if (t == 0)  v |= 32'h2;
    if (r == 0)  v |= 32'h4;
    if (r == 16) v |= 32'h8;
    return v;
  endfunction

  task automatic t_reset_state();
    logic [31:0] d;
    rdv('h000, d); eq("R1 ctrl", d, 0);
    rdv('h004, d); eq("R1 mask", d, 0);
    rdv('h100, d); eq("R1 cmd", d, 0);
    rdv('h084, d); eq("R1 dma addr", d, 0);
    rdv('h028, d); eq("R1 raw", d, 0);
    rdv('h020, d); eq("R1 fstat", d, 32'h6);
    eq("R1 strobes irq", {29'b0, seq_start, dma_start, irq}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr0('h000, 32'hFFFF_FFFF);
    rdv('h000, d); eq("R2 ctrl mask", d, 32'h0000_3F02);
    seq_busy = 1'b1;
    rdv('h024, d); eq("R13 busy", d, 1);
    wr0('h000, 32'h0);
    rdv('h000, d); eq("R3 ctrl held", d, 32'h0000_3F02);
    seq_busy = 1'b0;
    rdv('h024, d); eq("R13 idle", d, 0);
    wr0('h000, 32'h0000_1102);
    rdv('h000, d); eq("R2 ctrl idle write", d, 32'h0000_1102);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr0('h100, 32'h1234_5603);
    eq("R4 start pulse", {31'b0, seq_start}, 1);
    @(negedge clk);
    eq("R4 start one cycle", {31'b0, seq_start}, 0);
    rdv('h100, d); eq("R4 cmd stored", d, 32'h1234_5603);
    seq_busy = 1'b1;
    wr0('h100, 32'hDEAD_0000);
    eq("R4 no start busy", {31'b0, seq_start}, 0);
    seq_busy = 1'b0;
    rdv('h100, d); eq("R4 cmd kept", d, 32'h1234_5603);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    wr0('h084, 32'h8000_1000);
    wr0('h080, 32'h1);
    eq("R5 dma pulse", {31'b0, dma_start}, 1);
    rdv('h080, d); eq("R5 trigger reads 0", d, 0);
    eq("R5 dma one cycle", {31'b0, dma_start}, 0);
    rdv('h084, d); eq("R5 dma addr", d, 32'h8000_1000);
  endtask

  task automatic pulse(input logic x, input logic b, input logic s, input logic m);
    ev_xfer_done = x; ev_bus_err = b; ev_ser_err = s; ev_dma_done = m;
    @(negedge clk);
    ev_xfer_done = 0; ev_bus_err = 0; ev_ser_err = 0; ev_dma_done = 0;
  endtask

  task automatic t_events();
    logic [31:0] d;
    wr0('h008, 32'hFF);
    pulse(1, 0, 0, 0);
    rdv('h028, d); eq("R7 done bit4", d, 32'h10);
    pulse(0, 1, 1, 1);
    rdv('h028, d); eq("R7 err/dma bits", d, 32'hF0);
    wr0('h008, 32'h50);
    rdv('h028, d); eq("R8 partial clear", d, 32'hA0);
    wr0('h004, 32'h20);
    rdv('h01C, d); eq("R9 masked", d, 32'h80);
    eq("R9 irq on", {31'b0, irq}, 1);
    wr0('h004, 32'hA0);
    rdv('h01C, d); eq("R9 masked none", d, 0);
    eq("R9 irq off", {31'b0, irq}, 0);
    wr0('h004, 32'h0);
    rx_level = 5'd16; @(negedge clk);
    tx_level = 5'd3;  @(negedge clk);
    tx_level = 5'd0;  @(negedge clk);
    rdv('h028, d); eq("R7 full/empty edges", d & 32'h9, 32'h9);
    rx_level = 5'd0;
    wr0('h008, 32'hFF);
  endtask

  task automatic t_fstat();
    logic [31:0] d;
    tx_level = 5'd16; rx_level = 5'd0;
    rdv('h020, d); eq("R10 tx full", d, exp_fstat(16, 0));
    tx_level = 5'd0; rx_level = 5'd16;
    rdv('h020, d); eq("R10 rx full", d, exp_fstat(0, 16));
    tx_level = 5'd7; rx_level = 5'd9;
    rdv('h020, d); eq("R10 mid levels", d, exp_fstat(7, 9));
  endtask

  task automatic t_push_pop();
    logic [31:0] d;
    logic f;
    wr0('h008, 32'hFF);
    tx_level = 5'd5;
    bus_wdata = 0;
    wr('h108, 32'hCAFE_0001, f);
    eq("R11 push", {31'b0, f}, 1);
    rdv('h028, d); eq("R11 no overflow", d & 32'h4, 0);
    tx_level = 5'd16;
    wr('h108, 32'hCAFE_0002, f);
    eq("R11 no push full", {31'b0, f}, 0);
    rdv('h028, d); eq("R11 overflow bit2", d & 32'h4, 32'h4);
    rx_level = 5'd3; rx_rdata = 32'h5A5A_1234;
    rd('h108, d, f);
    eq("R12 pop data", d, 32'h5A5A_1234);
    eq("R12 pop strobe", {31'b0, f}, 1);
    rdv('h028, d); eq("R12 no underflow", d & 32'h2, 0);
    rx_level = 5'd0;
    rd('h108, d, f);
    eq("R12 no pop empty", {31'b0, f}, 0);
    rdv('h028, d); eq("R12 underflow bit1", d & 32'h2, 32'h2);
    tx_level = 5'd0;
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr0('h004, 32'h0F);
    wr0('h104, 32'h0001_0000);
    pulse(1, 0, 0, 0);
    wr0('h010, 32'h1);
    for (int i = 0; i < 4; i++) begin
      eq("R6 flush held", {31'b0, fifo_flush}, 1);
      if (i == 1) begin
        wr0('h000, 32'h0000_0002);
      end else begin
        rdv('h010, d); eq("R6 bit reads 1", d, 1);
      end
    end
    rdv('h010, d); eq("R6 bit cleared", d, 0);
    eq("R6 flush released", {31'b0, fifo_flush}, 0);
    rdv('h000, d); eq("R6 ctrl wiped", d, 0);
    rdv('h004, d); eq("R6 mask wiped", d, 0);
    rdv('h100, d); eq("R6 cmd wiped", d, 0);
    rdv('h104, d); eq("R6 addr wiped", d, 0);
    rdv('h028, d); eq("R6 raw wiped", d, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ctrl();
    t_cmd();
    t_dma();
    t_events();
    t_fstat();
    tx_level = 5'd0; rx_level = 5'd0;
    repeat (2) @(negedge clk);
    t_push_pop();
    t_soft_reset();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
    summary();
  end
endmodule